// File: doc/BRIEF.md
# Tri-State Phase-Frequency Comparator

This block is the digital core of a phase-locked loop's phase-frequency comparator. It receives a reference signal and a feedback signal, brings both onto a fast system clock, and looks for rising transitions on each. A three-state edge machine turns those transitions into a charge-pump command. The command has three forms: push up (drive high), pull down (drive low), or release (high impedance, with neither source nor sink). The command leaves the block as a drive value plus an output enable. A pad-level tri-state buffer can be wired straight to these two signals.

The machine reacts only to rising edges. If the reference edge comes before the feedback edge, the block drives high until the next feedback edge. If the feedback edge comes first, it drives low until the next reference edge. When both edges land in the same clock cycle, it releases. The block deliberately keeps the behaviour of a real three-state comparator when one input produces two edges and the other produces none. In that case the machine passes through the released state and ends in the opposite drive, so the phase sense reads reversed.

Two companion outputs are provided. The first is the exclusive-OR of the two synchronised inputs, which serves as a simple phase output. The second is a lock flag that is high whenever the machine is released. A synchronous reset puts the machine into the released state, so that it always starts from a known point.

Top module: `tri_phase_cmp`

## Requirements
- R1: While `rst` is high at a rising clock edge, the machine enters the released state and the synchroniser flops clear. After reset, `drv_en`=0, `drv_val`=0, `lock_out`=1 and `xor_out`=0.
- R2: The internal state codes are released=2'b00, pull-down=2'b01 and push-up=2'b10, and 2'b11 never occurs. `drv_en` is 1 in both drive states. `drv_val` is 1 only in push-up, so the command pairs (`drv_en`,`drv_val`) are (0,0), (1,0) and (1,1).
- R3: From released, a reference edge with no feedback edge in the same cycle gives push-up. Further lone reference edges keep push-up.
- R4: From push-up, a lone feedback edge gives released.
- R5: From released, a lone feedback edge gives pull-down. From pull-down, a lone reference edge gives released, and further lone feedback edges keep pull-down.
- R6: A reference edge and a feedback edge detected in the same clock cycle always lead to released, whatever the state before.
- R7: Falling edges and steady levels on either input leave the state unchanged.
- R8: Two lone reference edges applied from pull-down end in push-up. Two lone feedback edges applied from push-up end in pull-down.
- R9: `xor_out` is the XOR of the two inputs after the two-flop synchroniser. It reflects an input change made before clock edge k from edge k+1 onward.
- R10: `lock_out` is 1 exactly when `drv_en` is 0.
- R11: An input rising before clock edge k reaches `drv_en`/`drv_val` at edge k+2 (two synchroniser flops plus the state register). Before that edge the command is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous reference signal |
| fb_in | input | 1 | Asynchronous feedback signal from the oscillator divider |
| drv_val | output | 1 | Charge-pump drive level, meaningful when enabled |
| drv_en | output | 1 | Charge-pump drive enable; 0 means high impedance |
| xor_out | output | 1 | XOR phase output of the synchronised inputs |
| lock_out | output | 1 | High while the machine is released |

## Verification
The embedded assertions check the following on every cycle: the illegal state code never appears, the drive value is never set without the enable, and the lock flag and the enable are mutually exclusive. They also check each single-step transition of the table, which covers lead from released, clearing from push-up, lag from released, simultaneous edges, and no change without edges. Only the bench scenarios can show the multi-edge effects: the reversal when one input fires twice, the exact three-edge latency, the XOR timing, and the fact that falling edges do nothing. Each scenario observes these at the ports and compares them with an independent transition model.

// File: rtl/tri_phase_cmp.sv
module tri_phase_cmp #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic fb_in,
  output logic drv_val,
  output logic drv_en,
  output logic xor_out,
  output logic lock_out
);

  localparam logic [1:0] ST_REL  = 2'b00;
  localparam logic [1:0] ST_DOWN = 2'b01;
  localparam logic [1:0] ST_UP   = 2'b10;
  localparam int         PW      = SYNC_STAGES + 1;

  logic [PW-1:0] ref_pipe, fb_pipe;
  logic [1:0]    state, state_nx;
  logic          ref_s, fb_s, ref_rise, fb_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_pipe <= '0;
      fb_pipe  <= '0;
    end else begin
      ref_pipe <= {ref_pipe[PW-2:0], ref_in};
      fb_pipe  <= {fb_pipe[PW-2:0], fb_in};
    end
  end

  assign ref_s    = ref_pipe[SYNC_STAGES-1];
  assign fb_s     = fb_pipe[SYNC_STAGES-1];
  assign ref_rise = ref_s & ~ref_pipe[SYNC_STAGES];
  assign fb_rise  = fb_s & ~fb_pipe[SYNC_STAGES];

  always_comb begin
    state_nx = state;
    if (ref_rise && fb_rise) begin
      state_nx = ST_REL;
    end else if (ref_rise) begin
      case (state)
        ST_DOWN: state_nx = ST_REL;
        default: state_nx = ST_UP;
      endcase
    end else if (fb_rise) begin
      case (state)
        ST_UP:   state_nx = ST_REL;
        default: state_nx = ST_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_REL;
    else     state <= state_nx;
  end

  assign drv_en   = (state == ST_UP) || (state == ST_DOWN);
  assign drv_val  = (state == ST_UP);
  assign lock_out = (state == ST_REL);
  assign xor_out  = ref_s ^ fb_s;

  assert_legal_code_R2: assert property (@(posedge clk) disable iff (rst)
    state != 2'b11);

  assert_val_needs_en_R2: assert property (@(posedge clk) disable iff (rst)
    drv_val |-> drv_en);

  assert_lock_excl_R10: assert property (@(posedge clk) disable iff (rst)
    lock_out |-> !drv_en);

  assert_ref_lead_R3: assert property (@(posedge clk) disable iff (rst)
    (lock_out && ref_rise && !fb_rise) |=> (drv_en && drv_val));

  assert_fb_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (drv_en && drv_val && fb_rise && !ref_rise) |=> lock_out);

  assert_fb_lead_R5: assert property (@(posedge clk) disable iff (rst)
    (lock_out && fb_rise && !ref_rise) |=> (drv_en && !drv_val));

  assert_both_edges_R6: assert property (@(posedge clk) disable iff (rst)
    (ref_rise && fb_rise) |=> lock_out);

  assert_no_edge_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!ref_rise && !fb_rise) |=> ($stable(drv_en) && $stable(drv_val)));

endmodule

// File: tb/sim_tri_phase_cmp.sv
module sim_tri_phase_cmp;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic drv_val, drv_en, xor_out, lock_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // model state codes: 0 released, 1 pull-down, 2 push-up
  int m_st = 0;
  logic [2:0] m_r = '0, m_f = '0;

  always #5 clk = ~clk;

  tri_phase_cmp u0 (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .drv_val(drv_val), .drv_en(drv_en), .xor_out(xor_out), .lock_out(lock_out)
  );

  function automatic int next_st(int s, bit re, bit fe);
    if (re && fe) return 0;
    if (re) return (s == 1) ? 0 : 2;
    if (fe) return (s == 2) ? 0 : 1;
    return s;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_r <= '0; m_f <= '0; m_st <= 0;
    end else begin
      m_r <= {m_r[1:0], ref_in};
      m_f <= {m_f[1:0], fb_in};
      m_st <= next_st(m_st, m_r[1] & ~m_r[2], m_f[1] & ~m_f[2]);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // compares {drv_en, drv_val, lock_out} with explicit and model expectations
  task automatic chk_cmd(string req, logic [2:0] exp);
    logic [2:0] mdl;
    mdl = (m_st == 2) ? 3'b110 : (m_st == 1) ? 3'b100 : 3'b001;
    chk(req, {drv_en, drv_val, lock_out}, exp);
    chk({req, "_model"}, {drv_en, drv_val, lock_out}, mdl);
  endtask

  task automatic pulse(bit r, bit f);
    ref_in = r; fb_in = f;
    tick(2);
    ref_in = 1'b0; fb_in = 1'b0;
    tick(2);
  endtask

  task automatic t_reset();
    chk("R1", {drv_en, drv_val, lock_out}, 3'b001);
    chk("R1_xor", {2'b00, xor_out}, 3'b000);
  endtask

  task automatic t_lead();
    ref_in = 1'b1;
    tick(2);
    chk_cmd("R11_before", 3'b001);
    tick(1);
    chk_cmd("R3", 3'b110);
    tick(5);
    chk_cmd("R7_level", 3'b110);
    ref_in = 1'b0;
    tick(4);
    chk_cmd("R7_fall", 3'b110);
    pulse(1, 0);
    chk_cmd("R3_repeat", 3'b110);
    pulse(0, 1);
    chk_cmd("R4", 3'b001);
  endtask

  task automatic t_lag();
    pulse(0, 1);
    chk_cmd("R5_down", 3'b100);
    pulse(0, 1);
    chk_cmd("R5_repeat", 3'b100);
    pulse(1, 0);
    chk_cmd("R5_release", 3'b001);
  endtask

  task automatic t_inphase();
    pulse(1, 1);
    chk_cmd("R6_from_rel", 3'b001);
    pulse(1, 0);
    pulse(1, 1);
    chk_cmd("R6_from_up", 3'b001);
    pulse(0, 1);
    pulse(1, 1);
    chk_cmd("R6_from_down", 3'b001);
  endtask

  task automatic t_double();
    pulse(0, 1);
    chk_cmd("R8_start_down", 3'b100);
    pulse(1, 0);
    chk_cmd("R8_mid", 3'b001);
    pulse(1, 0);
    chk_cmd("R8_reversed_up", 3'b110);
    pulse(0, 1);
    pulse(0, 1);
    chk_cmd("R8_reversed_down", 3'b100);
    pulse(1, 0);
  endtask

  task automatic t_xor();
    ref_in = 1'b1;
    tick(1);
    chk("R9_latency", {2'b00, xor_out}, 3'b000);
    tick(1);
    chk("R9_diff", {2'b00, xor_out}, 3'b001);
    fb_in = 1'b1;
    tick(2);
    chk("R9_same", {2'b00, xor_out}, 3'b000);
    chk("R10", {2'b00, lock_out}, {2'b00, ~drv_en});
    ref_in = 1'b0; fb_in = 1'b0;
    tick(4);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_lead();
    t_lag();
    t_inphase();
    t_double();
    t_xor();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule